// File: doc/BRIEF.md
# Hash Message Word Expander

This block turns one 512-bit message block into the per-round word stream needed by a 64-round compression engine. After a start pulse it captures the block, splits it into sixteen 32-bit big-endian words, and then delivers one pair per round: the schedule word W[j] and the derived word W'[j] = W[j] ^ W[j+4]. Schedule words past the sixteenth are generated on the fly by the recurrence W[j] = P1(W[j-16] ^ W[j-9] ^ rol(W[j-3],15)) ^ rol(W[j-13],7) ^ W[j-6], where P1(x) = x ^ rol(x,15) ^ rol(x,23).

Only a sixteen-word sliding window is stored. The oldest entry of the window is the word being emitted, and the entry four places further on supplies the partner for W'. Each accepted pair shifts the window by one place and appends the next generated word. Pairs leave through a valid/ready handshake, so the round engine can stall the stream at any cycle. After the pair for round 63 is accepted the block raises a done flag and waits for the next start pulse.

Top module: `hx_msg_expand`

## Requirements
- R1: While reset is low and in the first cycle after it, `out_valid_o` and `done_o` are 0.
- R2: A `start_i` pulse seen while `out_valid_o` is 0 captures `block_i`; on the next cycle `out_valid_o` is 1 and `round_o` is 0. Byte n of the block is `block_i[511-8n -: 8]`, and input word k has byte 4k in bits 31:24 through byte 4k+3 in bits 7:0.
- R3: For rounds 0 to 15, `w_o` equals input word number `round_o` unchanged.
- R4: For rounds 16 to 63, `w_o` follows the recurrence with P1 given above.
- R5: For every round j, `wprime_o` equals W[j] ^ W[j+4], using generated words up to W[67].
- R6: While `out_valid_o` is 1 and `out_ready_i` is 0, `w_o`, `wprime_o` and `round_o` keep their values on the next cycle, and `out_valid_o` stays 1.
- R7: Each accepted pair (valid and ready high at a clock edge) advances `round_o` by exactly one; the 64 pairs of a block are delivered in order 0..63 with none skipped or repeated, and `out_valid_o` stays 1 between them.
- R8: The cycle after the round-63 pair is accepted, `out_valid_o` is 0 and `done_o` is 1; `done_o` stays 1 until the next accepted start, and is never 1 together with `out_valid_o`.
- R9: A `start_i` pulse while `out_valid_o` is 1 is ignored: the current stream continues with the words of the block already captured.
- R10: A start after `done_o` captures a fresh block, clears `done_o` and begins again at round 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Capture `block_i` and begin a new stream when idle |
| block_i | input | 512 | Message block, byte 0 in the top eight bits |
| out_ready_i | input | 1 | Round engine accepts the current pair |
| out_valid_o | output | 1 | A pair is presented |
| w_o | output | 32 | Schedule word W[round] |
| wprime_o | output | 32 | Derived word W[round] ^ W[round+4] |
| round_o | output | 6 | Round index of the presented pair |
| done_o | output | 1 | All 64 pairs of the block have been accepted |

## Verification
The hardest situation to reach is a stall that lands exactly on the cycle when the window must shift in a freshly generated word, combined with a start pulse arriving mid-stream. The bench drives `out_ready_i` from a pseudo-random pattern with long stall bursts so that stalls fall on many round indices, including the boundary at round 16 where generated words first appear and the final round 63, and it raises `start_i` with a different block while the stream is running to show that the captured words are untouched. Every accepted pair is compared against a behavioural model that computes all 68 schedule words from the block.

// File: rtl/hx_pkg.sv
// Shared constants and word functions for the message expander.
// Assumes 32-bit words, 16-word blocks and 64 rounds.
package hx_pkg;
    localparam int WORD_W      = 32;
    localparam int BLOCK_WORDS = 16;
    localparam int BLOCK_BITS  = WORD_W * BLOCK_WORDS;
    localparam int ROUNDS      = 64;
    localparam int LOOKAHEAD   = 4;
    localparam int ROUND_W     = $clog2(ROUNDS);

    typedef logic [WORD_W-1:0] word_t;

    // Left rotate by a fixed amount.
    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    // Permutation applied inside the expansion recurrence.
    function automatic word_t perm1(input word_t x);
        return x ^ rotl(x, 15) ^ rotl(x, 23);
    endfunction

    // Next schedule word from window taps at offsets 0, 3, 7, 10, 13.
    function automatic word_t grow_word(input word_t t0, input word_t t3,
                                        input word_t t7, input word_t t10,
                                        input word_t t13);
        return perm1(t0 ^ t7 ^ rotl(t13, 15)) ^ rotl(t3, 7) ^ t10;
    endfunction
endpackage

// File: rtl/hx_be_unpack.sv
// Splits a flat block into words, first byte most significant.
// Purely combinational; assumes byte 0 occupies the top eight bits.
module hx_be_unpack
    import hx_pkg::*;
#(
    parameter int NWORDS = BLOCK_WORDS
) (
    input  logic [NWORDS*WORD_W-1:0] block_i,
    output word_t [NWORDS-1:0]       words_o
);
    localparam int TOP = NWORDS * WORD_W - 1;

    genvar k;
    generate
        for (k = 0; k < NWORDS; k++) begin : g_word
            // Word k takes bytes 4k..4k+3 with byte 4k in its top bits.
            assign words_o[k] = block_i[TOP - k*WORD_W -: WORD_W];
        end
    endgenerate
endmodule

// File: rtl/hx_word_window.sv
// Sixteen-word sliding window holding W[j]..W[j+15].
// Load fills it from the block; shift drops W[j] and appends W[j+16].
// Assumes load and shift are never requested in the same cycle.
module hx_word_window
    import hx_pkg::*;
#(
    parameter int NW = BLOCK_WORDS,
    parameter int AHEAD = LOOKAHEAD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             shift_i,
    input  word_t [NW-1:0]   fill_i,
    output word_t            head_o,
    output word_t            ahead_o
);
    word_t win [NW];
    word_t fresh;

    // Generate the word that enters at the tail on a shift.
    always_comb fresh = grow_word(win[0], win[3], win[7], win[10], win[13]);

    // Window register: reset, load, shift or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) win[i] <= '0;
        end else if (load_i) begin
            for (int i = 0; i < NW; i++) win[i] <= fill_i[i];
        end else if (shift_i) begin
            for (int i = 0; i < NW - 1; i++) win[i] <= win[i+1];
            win[NW-1] <= fresh;
        end
    end

    assign head_o  = win[0];
    assign ahead_o = win[AHEAD];

    // R6: with no load and no shift the presented words do not move.
    a_r6_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !shift_i) |=> ($stable(head_o) && $stable(ahead_o)));

    // R7: a shift moves every word one place toward the head.
    a_r7_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> (head_o == $past(win[1])));
endmodule

// File: rtl/hx_round_seq.sv
// Round sequencer: tracks valid, round index and done.
// Start is honoured only when no stream is active.
module hx_round_seq
    import hx_pkg::*;
#(
    parameter int NROUNDS = ROUNDS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic                         ready_i,
    output logic                         load_o,
    output logic                         shift_o,
    output logic                         valid_o,
    output logic [$clog2(NROUNDS)-1:0]   round_o,
    output logic                         done_o
);
    localparam int CW = $clog2(NROUNDS);
    localparam logic [CW-1:0] LAST = CW'(NROUNDS - 1);

    logic          valid_q, done_q;
    logic [CW-1:0] round_q;

    assign load_o  = start_i && !valid_q;
    assign shift_o = valid_q && ready_i;

    // Advance the stream state on start and on each accepted pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            round_q <= '0;
        end else if (load_o) begin
            valid_q <= 1'b1;
            done_q  <= 1'b0;
            round_q <= '0;
        end else if (shift_o) begin
            if (round_q == LAST) begin
                valid_q <= 1'b0;
                done_q  <= 1'b1;
            end else begin
                round_q <= round_q + 1'b1;
            end
        end
    end

    assign valid_o = valid_q;
    assign round_o = round_q;
    assign done_o  = done_q;

    // R2: an accepted start presents round 0 on the next cycle.
    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !valid_o) |=> (valid_o && round_o == '0));

    // R6: a stalled pair stays presented with the same index.
    a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(round_o)));

    // R7: every accepted pair below the last advances the index by one.
    a_r7_round_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && round_o != LAST) |=>
            (valid_o && round_o == $past(round_o) + 1'b1));

    // R8: the last accepted pair ends the stream with done raised.
    a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && round_o == LAST) |=> (done_o && !valid_o));

    // R8: done and valid are never high together.
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && valid_o));

    // R9: a start during a stream leaves the index untouched.
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && valid_o && !ready_i) |=> (round_o == $past(round_o)));
endmodule

// File: rtl/hx_msg_expand.sv
// Message word expander top: captures a 512-bit block on start and
// streams 64 (W, W') pairs over a valid/ready handshake.
// Assumes the consumer holds ready stable only relative to clock edges.
module hx_msg_expand
    import hx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [511:0]          block_i,
    input  logic                  out_ready_i,
    output logic                  out_valid_o,
    output logic [31:0]           w_o,
    output logic [31:0]           wprime_o,
    output logic [5:0]            round_o,
    output logic                  done_o
);
    word_t [BLOCK_WORDS-1:0] words;
    word_t                   head, ahead;
    logic                    load, shift;

    // Byte-order conversion of the incoming block.
    hx_be_unpack #(.NWORDS(BLOCK_WORDS)) u_unpack (
        .block_i (block_i),
        .words_o (words)
    );

    // Round bookkeeping and handshake.
    hx_round_seq #(.NROUNDS(ROUNDS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .ready_i (out_ready_i),
        .load_o  (load),
        .shift_o (shift),
        .valid_o (out_valid_o),
        .round_o (round_o),
        .done_o  (done_o)
    );

    // Sliding schedule window.
    hx_word_window #(.NW(BLOCK_WORDS), .AHEAD(LOOKAHEAD)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .fill_i  (words),
        .head_o  (head),
        .ahead_o (ahead)
    );

    // Output pair: current word and its xor with the word four ahead.
    assign w_o      = head;
    assign wprime_o = head ^ ahead;

    // R1: nothing is presented right after reset.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!out_valid_o && !done_o));
endmodule

// File: tb/tb_hx_msg_expand.sv
`timescale 1ns/1ps
module tb_hx_msg_expand;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [511:0] block_i = '0;
    logic         out_ready_i = 1'b0;
    logic         out_valid_o;
    logic [31:0]  w_o, wprime_o;
    logic [5:0]   round_o;
    logic         done_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    hx_msg_expand dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .block_i(block_i),
        .out_ready_i(out_ready_i), .out_valid_o(out_valid_o), .w_o(w_o),
        .wprime_o(wprime_o), .round_o(round_o), .done_o(done_o)
    );

    // Behavioural reference: all 68 schedule words of one block.
    logic [31:0] ref_w [68];

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        logic [31:0] r = x;
        for (int i = 0; i < n; i++) r = {r[30:0], r[31]};
        return r;
    endfunction

    task automatic build_ref(input logic [511:0] blk);
        for (int k = 0; k < 16; k++) begin
            logic [31:0] v = '0;
            for (int b = 0; b < 4; b++)
                v = {v[23:0], blk[511 - 8*(4*k+b) -: 8]};
            ref_w[k] = v;
        end
        for (int j = 16; j < 68; j++) begin
            logic [31:0] x = ref_w[j-16] ^ ref_w[j-9] ^ rl(ref_w[j-3], 15);
            ref_w[j] = (x ^ rl(x, 15) ^ rl(x, 23)) ^ rl(ref_w[j-13], 7) ^ ref_w[j-6];
        end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [511:0] rand_block();
        logic [511:0] b;
        for (int i = 0; i < 16; i++) b[i*32 +: 32] = $urandom;
        return b;
    endfunction

    // Run one block; mode 0 = always ready, 1 = random ready, 2 = bursty.
    task automatic run_block(input logic [511:0] blk, input int mode,
                             input bit poke, input string tag);
        int idx = 0;
        int guard = 0;
        bit was_stall = 1'b0;
        logic [31:0] pw = '0, pwp = '0;
        logic [5:0]  pr = '0;
        build_ref(blk);
        block_i = blk;
        start_i = 1'b1;
        out_ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        block_i = rand_block();
        // R2: index 0 presented right after the accepted start.
        chk(out_valid_o && round_o == 6'd0 && !done_o, {"R2 start ", tag},
            {57'd0, out_valid_o, round_o}, {57'd0, 1'b1, 6'd0});
        while (idx < 64 && guard < 5000) begin
            guard++;
            if (was_stall)
                // R6: stalled pair held.
                chk(out_valid_o && w_o == pw && wprime_o == pwp && round_o == pr,
                    {"R6 hold ", tag}, {w_o, wprime_o}, {pw, pwp});
            // R7: valid stays high until all 64 pairs are taken.
            chk(out_valid_o && !done_o, {"R7 valid ", tag},
                {63'd0, out_valid_o}, 64'd1);
            case (mode)
                0: out_ready_i = 1'b1;
                1: out_ready_i = $urandom_range(0, 1) == 1;
                default: out_ready_i = ((idx / 5) % 2 == 0) ? 1'b1
                                       : ($urandom_range(0, 3) == 0);
            endcase
            start_i = poke && (idx == 20 || idx == 63);
            if (out_ready_i && out_valid_o) begin
                chk(round_o == idx[5:0], {"R7 order ", tag},
                    {58'd0, round_o}, {58'd0, idx[5:0]});
                chk(w_o == ref_w[idx], {idx < 16 ? "R3 word " : "R4 word ", tag},
                    {32'd0, w_o}, {32'd0, ref_w[idx]});
                chk(wprime_o == (ref_w[idx] ^ ref_w[idx+4]), {"R5 wprime ", tag},
                    {32'd0, wprime_o}, {32'd0, ref_w[idx] ^ ref_w[idx+4]});
                idx++;
                was_stall = 1'b0;
            end else begin
                was_stall = 1'b1;
                pw = w_o; pwp = wprime_o; pr = round_o;
            end
            @(negedge clk);
            start_i = 1'b0;
        end
        // R8: stream ends with done high and valid low, and done holds.
        for (int c = 0; c < 4; c++) begin
            chk(done_o && !out_valid_o, {"R8 done ", tag},
                {62'd0, done_o, out_valid_o}, {62'd0, 2'b10});
            out_ready_i = (c % 2 == 0);
            @(negedge clk);
        end
    endtask

    initial begin
        logic [511:0] inc_blk;
        for (int n = 0; n < 64; n++) inc_blk[511 - 8*n -: 8] = n[7:0];
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(!out_valid_o && !done_o, "R1 reset", {62'd0, out_valid_o, done_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid_o && !done_o, "R1 after reset",
            {62'd0, out_valid_o, done_o}, 64'd0);
        // R2 byte order: incrementing bytes, first word must be 00010203.
        block_i = inc_blk;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(w_o == 32'h00010203, "R2 byte order", {32'd0, w_o}, 64'h00010203);
        chk(wprime_o == (32'h00010203 ^ 32'h10111213), "R5 first wprime",
            {32'd0, wprime_o}, {32'd0, 32'h00010203 ^ 32'h10111213});
        // Finish that stream at full rate, then run further blocks.
        out_ready_i = 1'b1;
        repeat (64) @(negedge clk);
        out_ready_i = 1'b0;
        chk(done_o && !out_valid_o, "R8 first done", {62'd0, done_o, out_valid_o},
            {62'd0, 2'b10});
        run_block(inc_blk, 0, 1'b0, "incr");
        run_block(rand_block(), 1, 1'b1, "rand R9");
        run_block(rand_block(), 2, 1'b1, "burst R10");
        run_block({16{32'hFFFFFFFF}}, 1, 1'b0, "ones");
        run_block('0, 2, 1'b0, "zero");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule